// File: doc/BRIEF.md
# Wrapper Serial Path Router

This block sets up the scan path of a core test wrapper. It takes the decoded instruction code and the instruction-register select line. From them it decides which shift segments sit between the serial test input and the serial test output. The possible segments are the instruction register, a one-bit bypass stage, the boundary chain alone, or the boundary chain followed by every core scan chain. For the two parallel instructions, the boundary chain and the core scan chains are taken off the serial pins. Each is then wired between its own parallel input line and its own parallel output line.

The boundary cells, the core scan chains and the instruction register are outside the block. The router feeds their serial inputs, gates their shift enables and collects their serial outputs. It contains the bypass flop and the two output multiplexers. The first multiplexer picks a data-register output. The second chooses between that result and the instruction register. In the parallel modes the serial output is taken from the bypass stage, so a daisy chain of wrappers still passes serial data through this one with a delay of one bit.

The serial streams carry one bit per shift clock with no handshake, so every pin is plain. Instruction code and select are assumed stable while shifting.

Top module: `wpath_router`

## Requirements
- R1: While reset (active low, asynchronous) is asserted, the bypass stage is cleared. With code 0 and select low, the serial output then reads 0.
- R2: The bypass stage loads the serial input at each rising clock edge where shift is high, and holds otherwise. Under code 0 (bypass) with select low, the serial output equals the bypass stage, giving a path length of 1.
- R3: With select high, the serial output equals the instruction-register serial output under every code. Both segment shift enables are low.
- R4: Code 1 (internal serial) chains serial input → boundary → scan chain 0 → … → last scan chain → serial output. Both shift enables follow the shift input. The path length is the sum of all segment lengths.
- R5: Codes 2 (internal, boundary only) and 3 (external serial) place only the boundary chain between the serial pins. In these codes the scan shift enable, the scan inputs and all parallel outputs are 0.
- R6: Code 4 (internal parallel) feeds the boundary chain from parallel input 0 and drives parallel output 0 from it. Scan chain k is fed from parallel input k+1 and drives parallel output k+1. Everything shifts together, and the serial output follows the bypass stage.
- R7: Code 5 (external parallel) feeds the boundary chain from parallel input 0 to parallel output 0. The scan chains are idle: shift enable low, inputs 0, parallel outputs 1 and up at 0. The serial output follows the bypass stage.
- R8: Unassigned codes 6 and 7 behave exactly as code 0.
- R9: The functional-mode output is high only for the bypass behaviour (codes 0, 6, 7). In that mode no segment shifts and every segment input and parallel output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrck | input | 1 | Wrapper shift clock |
| wrstn | input | 1 | Asynchronous reset, active low |
| sel_ir | input | 1 | High: instruction register on the serial path |
| shift_en | input | 1 | Shift request for the selected path |
| instr | input | 3 | Decoded instruction code |
| wsi | input | 1 | Serial test input |
| ir_so | input | 1 | Serial output of the instruction register |
| wso | output | 1 | Serial test output |
| bnd_so | input | 1 | Serial output of the boundary chain |
| bnd_si | output | 1 | Serial input to the boundary chain |
| bnd_shift | output | 1 | Boundary chain shift enable |
| scan_so | input | NSCAN | Serial outputs of the core scan chains |
| scan_si | output | NSCAN | Serial inputs to the core scan chains |
| scan_shift | output | 1 | Core scan chain shift enable |
| par_in | input | NSCAN+1 | Parallel test inputs (0 = boundary, k+1 = scan chain k) |
| par_out | output | NSCAN+1 | Parallel test outputs (same numbering) |
| func_mode | output | 1 | High when the core runs in normal mode |

## Verification
Two functions can act on the same clock edge. One is the bypass stage, which keeps shifting the serial pins. The other is the parallel chains, which shift boundary and scan data from the parallel lines. A further collision is a select-high cycle that lands in the middle of a data-register shift. The bench drives random serial, parallel and instruction-register bits with shift and select toggled at random under every code. Each cycle it compares all outputs against a behavioural model that has its own boundary and scan segments. It then measures the end-to-end length of each path by sending a single one through flushed segments.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
  typedef enum logic [2:0] {
    OP_BYPASS  = 3'd0,
    OP_INT_SER = 3'd1,
    OP_INT_BND = 3'd2,
    OP_EXT_SER = 3'd3,
    OP_INT_PAR = 3'd4,
    OP_EXT_PAR = 3'd5
  } op_e;

  localparam logic [1:0] SEL_BYP  = 2'd0;
  localparam logic [1:0] SEL_BND  = 2'd1;
  localparam logic [1:0] SEL_SCAN = 2'd2;

  typedef struct packed {
    logic       bnd_use;
    logic       scan_use;
    logic       par;
    logic       func;
    logic [1:0] sel;
  } route_t;
endpackage

// File: rtl/wpr_decode.sv
module wpr_decode
  import wpr_pkg::*;
(
  input  logic [2:0] code,
  output route_t     rt
);
  always_comb begin
    rt = '{bnd_use: 1'b0, scan_use: 1'b0, par: 1'b0, func: 1'b1, sel: SEL_BYP};
    case (code)
      OP_INT_SER: rt = '{bnd_use: 1'b1, scan_use: 1'b1, par: 1'b0, func: 1'b0, sel: SEL_SCAN};
      OP_INT_BND,
      OP_EXT_SER: rt = '{bnd_use: 1'b1, scan_use: 1'b0, par: 1'b0, func: 1'b0, sel: SEL_BND};
      OP_INT_PAR: rt = '{bnd_use: 1'b1, scan_use: 1'b1, par: 1'b1, func: 1'b0, sel: SEL_BYP};
      OP_EXT_PAR: rt = '{bnd_use: 1'b1, scan_use: 1'b0, par: 1'b1, func: 1'b0, sel: SEL_BYP};
      default:    rt = '{bnd_use: 1'b0, scan_use: 1'b0, par: 1'b0, func: 1'b1, sel: SEL_BYP};
    endcase
  end
endmodule

// File: rtl/wpr_bypass.sv
module wpr_bypass (
  input  logic clk,
  input  logic rst_n,
  input  logic shift,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (shift) q <= d;
  end
endmodule

// File: rtl/wpr_route.sv
module wpr_route #(
  parameter int NSCAN = 2
) (
  input  logic             bnd_use,
  input  logic             scan_use,
  input  logic             par,
  input  logic             sel_ir,
  input  logic             shift_en,
  input  logic             wsi,
  input  logic [NSCAN:0]   par_in,
  input  logic             bnd_so,
  input  logic [NSCAN-1:0] scan_so,
  output logic             bnd_si,
  output logic [NSCAN-1:0] scan_si,
  output logic [NSCAN:0]   par_out,
  output logic             bnd_shift,
  output logic             scan_shift
);
  logic dr_shift;
  assign dr_shift   = shift_en & ~sel_ir;
  assign bnd_shift  = dr_shift & bnd_use;
  assign scan_shift = dr_shift & scan_use;

  assign bnd_si     = !bnd_use ? 1'b0 : (par ? par_in[0] : wsi);
  assign par_out[0] = (par & bnd_use) ? bnd_so : 1'b0;

  for (genvar k = 0; k < NSCAN; k++) begin : g_chain
    logic ser_src;
    if (k == 0) begin : g_head
      assign ser_src = bnd_so;
    end else begin : g_link
      assign ser_src = scan_so[k-1];
    end
    assign scan_si[k]   = !scan_use ? 1'b0 : (par ? par_in[k+1] : ser_src);
    assign par_out[k+1] = (par & scan_use) ? scan_so[k] : 1'b0;
  end
endmodule

// File: rtl/wpr_outmux.sv
module wpr_outmux
  import wpr_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       sel_ir,
  input  logic       byp_so,
  input  logic       bnd_so,
  input  logic       tail_so,
  input  logic       ir_so,
  output logic       wso
);
  logic dr_so;
  always_comb begin
    case (sel)
      SEL_BND:  dr_so = bnd_so;
      SEL_SCAN: dr_so = tail_so;
      default:  dr_so = byp_so;
    endcase
  end
  assign wso = sel_ir ? ir_so : dr_so;
endmodule

// File: rtl/wpath_router.sv
module wpath_router
  import wpr_pkg::*;
#(
  parameter int NSCAN = 2
) (
  input  logic             wrck,
  input  logic             wrstn,
  input  logic             sel_ir,
  input  logic             shift_en,
  input  logic [2:0]       instr,
  input  logic             wsi,
  input  logic             ir_so,
  output logic             wso,
  input  logic             bnd_so,
  output logic             bnd_si,
  output logic             bnd_shift,
  input  logic [NSCAN-1:0] scan_so,
  output logic [NSCAN-1:0] scan_si,
  output logic             scan_shift,
  input  logic [NSCAN:0]   par_in,
  output logic [NSCAN:0]   par_out,
  output logic             func_mode
);
  route_t rt;
  logic   byp_q;

  wpr_decode u_dec (.code(instr), .rt(rt));

  wpr_bypass u_byp (.clk(wrck), .rst_n(wrstn), .shift(shift_en), .d(wsi), .q(byp_q));

  wpr_route #(.NSCAN(NSCAN)) u_route (
    .bnd_use(rt.bnd_use), .scan_use(rt.scan_use), .par(rt.par),
    .sel_ir(sel_ir), .shift_en(shift_en), .wsi(wsi), .par_in(par_in),
    .bnd_so(bnd_so), .scan_so(scan_so), .bnd_si(bnd_si), .scan_si(scan_si),
    .par_out(par_out), .bnd_shift(bnd_shift), .scan_shift(scan_shift)
  );

  wpr_outmux u_mux (
    .sel(rt.sel), .sel_ir(sel_ir), .byp_so(byp_q), .bnd_so(bnd_so),
    .tail_so(scan_so[NSCAN-1]), .ir_so(ir_so), .wso(wso)
  );

  assign func_mode = rt.func;

  // R3
  ir_sel_freeze_chk: assert property (@(posedge wrck) disable iff (!wrstn)
    sel_ir |-> (!bnd_shift && !scan_shift));

  // R9
  func_quiet_chk: assert property (@(posedge wrck) disable iff (!wrstn)
    func_mode |-> (!bnd_shift && !scan_shift && bnd_si == 1'b0 && scan_si == '0 && par_out == '0));

  // R2
  byp_delay_chk: assert property (@(posedge wrck) disable iff (!wrstn)
    (func_mode && shift_en && !sel_ir) |=> (!func_mode || sel_ir || wso == $past(wsi)));

  // R5
  bnd_only_chk: assert property (@(posedge wrck) disable iff (!wrstn)
    (instr == OP_INT_BND || instr == OP_EXT_SER) |-> (scan_si == '0 && !scan_shift && par_out == '0));

  // R7
  extp_idle_chk: assert property (@(posedge wrck) disable iff (!wrstn)
    (instr == OP_EXT_PAR) |-> (par_out[NSCAN:1] == '0 && !scan_shift && scan_si == '0));

  // R6
  par_wso_chk: assert property (@(posedge wrck) disable iff (!wrstn)
    (instr == OP_INT_PAR && shift_en && !sel_ir) |=> (instr != OP_INT_PAR || sel_ir || wso == $past(wsi)));
endmodule

// File: tb/wpath_router_tb.sv
module wpath_router_tb;
  localparam int CLK = 10;
  localparam int NS  = 2;
  localparam int LB  = 5;
  localparam int L0  = 3;
  localparam int L1  = 4;

  logic wrck = 0, wrstn = 0, sel_ir = 0, shift_en = 0, wsi = 0, ir_so = 0;
  logic [2:0] instr = 0;
  logic [NS:0] par_in = 0;
  logic wso, bnd_si, bnd_shift, scan_shift, func_mode;
  logic [NS-1:0] scan_si, scan_so;
  logic [NS:0] par_out;
  logic bnd_so;
  int total = 0, bad = 0;
  bit checking = 0;

  always #(CLK/2) wrck = ~wrck;

  wpath_router #(.NSCAN(NS)) u_dut (
    .wrck(wrck), .wrstn(wrstn), .sel_ir(sel_ir), .shift_en(shift_en), .instr(instr),
    .wsi(wsi), .ir_so(ir_so), .wso(wso), .bnd_so(bnd_so), .bnd_si(bnd_si),
    .bnd_shift(bnd_shift), .scan_so(scan_so), .scan_si(scan_si), .scan_shift(scan_shift),
    .par_in(par_in), .par_out(par_out), .func_mode(func_mode)
  );

  // environment segments
  logic [LB-1:0] bseg;
  logic [L0-1:0] s0;
  logic [L1-1:0] s1;
  assign bnd_so  = bseg[LB-1];
  assign scan_so = {s1[L1-1], s0[L0-1]};
  always @(posedge wrck or negedge wrstn) begin
    if (!wrstn) begin bseg <= '0; s0 <= '0; s1 <= '0; end
    else begin
      if (bnd_shift)  bseg <= {bseg[LB-2:0], bnd_si};
      if (scan_shift) begin s0 <= {s0[L0-2:0], scan_si[0]}; s1 <= {s1[L1-2:0], scan_si[1]}; end
    end
  end

  // reference bypass bit
  logic byp_m;
  always @(posedge wrck or negedge wrstn) begin
    if (!wrstn) byp_m <= 1'b0;
    else if (shift_en) byp_m <= wsi;
  end

  function automatic string tag_of(int c, bit s);
    if (s) return "R3";
    case (c)
      0: return "R2"; 1: return "R4"; 2, 3: return "R5";
      4: return "R6"; 5: return "R7"; default: return "R8";
    endcase
  endfunction

  // per-cycle comparison: {wso,bnd_si,bnd_shift,scan_si,scan_shift,par_out,func}
  always @(negedge wrck) begin
    if (checking && wrstn) begin
      logic [9:0] exp, act;
      logic act_sh, e_wso, e_bsi, e_bsh, e_ssh, e_fn;
      logic [1:0] e_ssi;
      logic [2:0] e_po;
      act_sh = shift_en && !sel_ir;
      e_wso = byp_m; e_bsi = 0; e_bsh = 0; e_ssi = 0; e_ssh = 0; e_po = 0; e_fn = 0;
      case (instr)
        3'd1: begin e_bsi = wsi; e_bsh = act_sh; e_ssi = {scan_so[0], bnd_so}; e_ssh = act_sh; e_wso = scan_so[1]; end
        3'd2, 3'd3: begin e_bsi = wsi; e_bsh = act_sh; e_wso = bnd_so; end
        3'd4: begin e_bsi = par_in[0]; e_bsh = act_sh; e_ssi = par_in[2:1]; e_ssh = act_sh;
                    e_po = {scan_so[1], scan_so[0], bnd_so}; end
        3'd5: begin e_bsi = par_in[0]; e_bsh = act_sh; e_po = {2'b00, bnd_so}; end
        default: e_fn = 1;
      endcase
      if (sel_ir) e_wso = ir_so;
      exp = {e_wso, e_bsi, e_bsh, e_ssi, e_ssh, e_po, e_fn};
      act = {wso, bnd_si, bnd_shift, scan_si, scan_shift, par_out, func_mode};
      total++;
      if (act !== exp) begin
        bad++;
        $display("FAIL %s code=%0d sel=%0b actual=%b expected=%b", tag_of(instr, sel_ir), instr, sel_ir, act, exp);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] a, logic [31:0] e);
    total++;
    if (a !== e) begin bad++; $display("FAIL %s actual=%0d expected=%0d", tag, a, e); end
  endtask

  task automatic run_random(int code, int n);
    instr = code[2:0];
    repeat (n) begin
      @(negedge wrck); #1;
      wsi = $urandom(); ir_so = $urandom(); par_in = $urandom();
      shift_en = ($urandom() % 8) != 0;
      sel_ir = ($urandom() % 8) == 0;
    end
  endtask

  // which < 0: serial pins; otherwise parallel line index
  task automatic measure(int code, int which, int expv, string tag);
    int got = -1;
    instr = code[2:0]; sel_ir = 0; shift_en = 1; wsi = 0; par_in = 0;
    repeat (30) begin @(negedge wrck); #1; end
    if (which < 0) wsi = 1; else par_in[which] = 1;
    for (int n = 1; n <= 40; n++) begin
      @(negedge wrck);
      if (got < 0 && ((which < 0) ? wso : par_out[which]) === 1'b1) got = n;
      #1; wsi = 0; par_in = 0;
    end
    chk(tag, got, expv);
  endtask

  initial begin
    #(CLK * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wsi = 1; shift_en = 1;
    repeat (3) @(negedge wrck);
    // R1: reset clears bypass stage
    chk("R1 wso in reset", wso, 0);
    chk("R1 shift gated in reset", bnd_shift | scan_shift, 0);
    #1; wrstn = 1; shift_en = 0; wsi = 0;
    @(negedge wrck);
    chk("R1 wso after reset", wso, 0);
    checking = 1;
    for (int c = 0; c < 8; c++) run_random(c, 60);
    run_random(4, 60); run_random(1, 60); run_random(5, 60);
    measure(0, -1, 1, "R2 bypass length");
    measure(6, -1, 1, "R8 code6 length");
    measure(1, -1, LB + L0 + L1, "R4 serial internal length");
    measure(2, -1, LB, "R5 boundary-only length");
    measure(3, -1, LB, "R5 external serial length");
    measure(4, 0, LB, "R6 parallel boundary length");
    measure(4, 1, L0, "R6 parallel scan0 length");
    measure(4, 2, L1, "R6 parallel scan1 length");
    measure(4, -1, 1, "R6 serial through bypass");
    measure(5, 0, LB, "R7 external parallel length");
    measure(5, -1, 1, "R7 serial through bypass");
    // R9: functional mode flag
    instr = 3'd7; @(negedge wrck); chk("R9 func code7", func_mode, 1);
    #1; instr = 3'd3; @(negedge wrck); chk("R9 func code3", func_mode, 0);
    checking = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule